// File: doc/BRIEF.md
# Memory Ordering Group Dispatcher

This block sits at the dispatch stage of a load/store pipeline. Every memory operation that enters it is placed in a memory group, and the block issues ordering edges that say which older groups the new one must wait for. Each operation carries three attributes: whether it may load, whether it may store, and whether it is a barrier. Four tracker registers hold the group IDs of the youngest load group, store group, load-barrier group and store-barrier group. A group ID of 0 means that no such group exists.

Back-to-back loads with no store between them are merged into one group. Stores always open a new group. Barriers and the no-alias mode decide whether each edge is a hard ordering or an alias-only ordering. The block keeps occupancy counts for the load and store queues and refuses an operation whose queue is full. It clears a tracker register when its group reports that all members have executed. Whether a group has begun executing is tracked elsewhere. The block presents the ID it wants to know about on `dom_query_gid` and receives the answer on `dom_executing` in the same cycle.

Top module: `memgrp_dispatch`

## Requirements
- R1: After reset, the first group allocated gets ID 1, and each later allocation gets the previous ID plus 1. An accepted memory operation always reports a nonzero `out_gid`.
- R2: An operation with may-store set always gets a freshly allocated ID. Edge slot 0 points it at the load dominator, which is the larger of the load tracker and the load-barrier tracker, when that value is nonzero. This edge has hard = 1 only when `no_alias` = 0.
- R3: For a store, edge slot 1 points at the store-barrier tracker when it is nonzero, with hard = 1. Edge slot 2 points at the store tracker when it is nonzero and differs from the store-barrier tracker, with hard = !`no_alias`. A valid edge has `edge_succ` equal to `out_gid`. An invalid slot drives pred, succ and hard as 0.
- R4: An accepted store becomes the store tracker. If it is a barrier it also becomes the store-barrier tracker. If it may also load, it becomes the load tracker, and it becomes the load-barrier tracker too when it is a barrier.
- R5: A load that does not store opens a new group if any of these holds:
  - it is a barrier;
  - the load dominator is 0;
  - the dominator equals the load-barrier tracker;
  - the dominator is less than or equal to the store tracker;
  - `dom_executing` is 1.
  Otherwise it joins the load tracker's group: `out_gid` is that ID, no edge is valid and no ID is consumed.
- R6: A load that opens a new group gets a hard edge in slot 0 to the store tracker when that tracker is nonzero and `no_alias` = 0. Slot 1 is a hard edge to the load dominator for a barrier load, or to the load-barrier tracker for a plain load, when that ID is nonzero. The new group becomes the load tracker, and also the load-barrier tracker if it is a barrier.
- R7: A may-load operation takes a load-queue slot when it is accepted, and a may-store operation takes a store-queue slot. `ret_load` and `ret_store` each free one slot. While a queue holds LQ_DEPTH (or SQ_DEPTH) entries, `in_ready` is 0 for any operation that needs that queue. Depths below 1 are rejected at elaboration.
- R8: `avail_status` is 1 when may-load is set and the load queue is full. Otherwise it is 2 when may-store is set and the store queue is full. Otherwise it is 0. The value 3 never occurs.
- R9: A cycle with `done_valid` = 1 resets to 0 every tracker that holds `done_gid`. This takes effect for `dom_query_gid` and for a dispatch in that same cycle.
- R10: After ID 2^GID_W-1 has been allocated, the next allocation stalls (`in_ready` = 0) until all four trackers are 0. That allocation then receives ID 1. Loads that join an existing group are not stalled.
- R11: `dom_query_gid` always shows the current load dominator, after any clearing from R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| no_alias | input | 1 | Assume memory operations never alias |
| in_valid | input | 1 | Operation offered |
| in_may_load | input | 1 | Operation may read memory |
| in_may_store | input | 1 | Operation may write memory |
| in_barrier | input | 1 | Operation has ordering side effects |
| in_ready | output | 1 | Operation can be accepted this cycle |
| avail_status | output | 2 | 0 available, 1 load queue full, 2 store queue full |
| out_gid | output | GID_W | Group assigned to the offered operation |
| edge_valid | output | 3 | Per-slot edge valid |
| edge_pred | output | 3*GID_W | Per-slot predecessor group |
| edge_succ | output | 3*GID_W | Per-slot successor group |
| edge_hard | output | 3 | Per-slot hard (1) or alias-only (0) ordering |
| dom_query_gid | output | GID_W | Load dominator whose execution state is asked for |
| dom_executing | input | 1 | Queried group has started executing |
| done_valid | input | 1 | A group has fully executed |
| done_gid | input | GID_W | ID of the finished group |
| ret_load | input | 1 | Free one load-queue slot |
| ret_store | input | 1 | Free one store-queue slot |

## Verification
The group ID, the edges, `in_ready`, `avail_status` and `dom_query_gid` all depend on the offered attributes and the registered trackers through combinational logic only. The bench therefore drives inputs just after a falling edge and samples these outputs 1 ns later, before the rising edge that accepts the operation. Tracker updates (R4, R6, R9), queue counts (R7) and the ID counter (R10) show up one rising edge later. They are checked on the next operation's edges and ready value, or on `dom_query_gid`, in the following low phase. The one exception is the same-cycle clearing of R9, which is sampled while `done_valid` is still high.

// File: rtl/memgrp_pkg.sv
package memgrp_pkg;
    localparam int NUM_EDGES = 3;
    localparam int SLOT_LOAD_SIDE  = 0;
    localparam int SLOT_BARRIER    = 1;
    localparam int SLOT_STORE_SIDE = 2;
    localparam int NUM_QUEUES = 2;
    localparam int Q_LOAD  = 0;
    localparam int Q_STORE = 1;

    typedef enum logic [1:0] {
        AVL_OK      = 2'd0,
        AVL_LQ_FULL = 2'd1,
        AVL_SQ_FULL = 2'd2
    } avail_e;
endpackage

// File: rtl/memgrp_qcount.sv
module memgrp_qcount #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    output logic full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (take && !give) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end else if (give && !take && s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign full = (s_q.cnt == LIMIT);
endmodule

// File: rtl/memgrp_gid_alloc.sv
module memgrp_gid_alloc #(
    parameter int GID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             idle,
    output logic [GID_W-1:0] next_gid,
    output logic             can_alloc
);
    localparam logic [GID_W-1:0] GID_MAX = '1;
    localparam logic [GID_W-1:0] GID_ONE = GID_W'(1);

    typedef struct packed {
        logic [GID_W-1:0] next;
        logic             wrapped;
    } st_t;

    st_t s_q, s_d;

    assign can_alloc = !s_q.wrapped || idle;
    assign next_gid  = s_q.next;

    always_comb begin
        s_d = s_q;
        if (alloc) begin
            if (s_q.next == GID_MAX) begin
                s_d.next    = GID_ONE;
                s_d.wrapped = 1'b1;
            end else begin
                s_d.next    = s_q.next + 1'b1;
                s_d.wrapped = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.next    <= GID_ONE;
            s_q.wrapped <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/memgrp_rules.sv
module memgrp_rules
    import memgrp_pkg::*;
#(
    parameter int GID_W = 8
) (
    input  logic                            no_alias,
    input  logic                            op_ld,
    input  logic                            op_st,
    input  logic                            op_bar,
    input  logic                            dom_exec,
    input  logic [GID_W-1:0]                next_gid,
    input  logic [GID_W-1:0]                cur_ld,
    input  logic [GID_W-1:0]                cur_st,
    input  logic [GID_W-1:0]                cur_lb,
    input  logic [GID_W-1:0]                cur_sb,
    output logic [GID_W-1:0]                dom,
    output logic                            need_alloc,
    output logic [GID_W-1:0]                gid,
    output logic [NUM_EDGES-1:0]            ev,
    output logic [NUM_EDGES-1:0][GID_W-1:0] ep,
    output logic [NUM_EDGES-1:0]            eh,
    output logic [GID_W-1:0]                nx_ld,
    output logic [GID_W-1:0]                nx_st,
    output logic [GID_W-1:0]                nx_lb,
    output logic [GID_W-1:0]                nx_sb
);
    logic open_load;
    logic [NUM_EDGES-1:0] hard_raw;

    assign dom = (cur_ld > cur_lb) ? cur_ld : cur_lb;

    assign open_load = op_bar || (dom == '0) || (dom == cur_lb) ||
                       (dom <= cur_st) || dom_exec;

    always_comb begin
        need_alloc = 1'b0;
        gid        = '0;
        ev         = '0;
        ep         = '0;
        hard_raw   = '0;
        nx_ld      = cur_ld;
        nx_st      = cur_st;
        nx_lb      = cur_lb;
        nx_sb      = cur_sb;
        if (op_st) begin
            need_alloc = 1'b1;
            gid        = next_gid;
            ev[SLOT_LOAD_SIDE]        = (dom != '0);
            ep[SLOT_LOAD_SIDE]        = dom;
            hard_raw[SLOT_LOAD_SIDE]  = !no_alias;
            ev[SLOT_BARRIER]          = (cur_sb != '0);
            ep[SLOT_BARRIER]          = cur_sb;
            hard_raw[SLOT_BARRIER]    = 1'b1;
            ev[SLOT_STORE_SIDE]       = (cur_st != '0) && (cur_st != cur_sb);
            ep[SLOT_STORE_SIDE]       = cur_st;
            hard_raw[SLOT_STORE_SIDE] = !no_alias;
            nx_st = next_gid;
            if (op_bar) nx_sb = next_gid;
            if (op_ld) begin
                nx_ld = next_gid;
                if (op_bar) nx_lb = next_gid;
            end
        end else if (op_ld) begin
            if (open_load) begin
                need_alloc = 1'b1;
                gid        = next_gid;
                ev[SLOT_LOAD_SIDE]       = !no_alias && (cur_st != '0);
                ep[SLOT_LOAD_SIDE]       = cur_st;
                hard_raw[SLOT_LOAD_SIDE] = 1'b1;
                if (op_bar) begin
                    ev[SLOT_BARRIER] = (dom != '0);
                    ep[SLOT_BARRIER] = dom;
                end else begin
                    ev[SLOT_BARRIER] = (cur_lb != '0);
                    ep[SLOT_BARRIER] = cur_lb;
                end
                hard_raw[SLOT_BARRIER] = 1'b1;
                nx_ld = next_gid;
                if (op_bar) nx_lb = next_gid;
            end else begin
                gid = cur_ld;
            end
        end
        for (int i = 0; i < NUM_EDGES; i++) begin
            if (!ev[i]) ep[i] = '0;
        end
    end

    assign eh = ev & hard_raw;
endmodule

// File: rtl/memgrp_dispatch.sv
module memgrp_dispatch
    import memgrp_pkg::*;
#(
    parameter int GID_W    = 8,
    parameter int LQ_DEPTH = 16,
    parameter int SQ_DEPTH = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            no_alias,
    input  logic                            in_valid,
    input  logic                            in_may_load,
    input  logic                            in_may_store,
    input  logic                            in_barrier,
    output logic                            in_ready,
    output logic [1:0]                      avail_status,
    output logic [GID_W-1:0]                out_gid,
    output logic [2:0]                      edge_valid,
    output logic [2:0][GID_W-1:0]           edge_pred,
    output logic [2:0][GID_W-1:0]           edge_succ,
    output logic [2:0]                      edge_hard,
    output logic [GID_W-1:0]                dom_query_gid,
    input  logic                            dom_executing,
    input  logic                            done_valid,
    input  logic [GID_W-1:0]                done_gid,
    input  logic                            ret_load,
    input  logic                            ret_store
);
    if (LQ_DEPTH < 1 || SQ_DEPTH < 1) begin : g_bad_depth
        $error("memgrp_dispatch: queue depths must be at least 1");
    end

    typedef struct packed {
        logic [GID_W-1:0] ld;
        logic [GID_W-1:0] st;
        logic [GID_W-1:0] lb;
        logic [GID_W-1:0] sb;
    } trk_t;

    trk_t trk_q, trk_d, trk_clr;

    logic [NUM_QUEUES-1:0] q_take, q_give, q_full;
    logic                  fire, need_alloc, can_alloc, idle;
    logic [GID_W-1:0]      next_gid, gid;
    logic [NUM_EDGES-1:0]  ev, eh;
    logic [NUM_EDGES-1:0][GID_W-1:0] ep;
    logic [GID_W-1:0]      nx_ld, nx_st, nx_lb, nx_sb;
    logic                  q_blocked;

    // Completion clears any tracker holding the finished ID
    always_comb begin
        trk_clr = trk_q;
        if (done_valid && done_gid != '0) begin
            if (trk_q.ld == done_gid) trk_clr.ld = '0;
            if (trk_q.st == done_gid) trk_clr.st = '0;
            if (trk_q.lb == done_gid) trk_clr.lb = '0;
            if (trk_q.sb == done_gid) trk_clr.sb = '0;
        end
    end

    assign idle = (trk_clr == '0);

    memgrp_rules #(.GID_W(GID_W)) u_rules (
        .no_alias  (no_alias),
        .op_ld     (in_may_load),
        .op_st     (in_may_store),
        .op_bar    (in_barrier),
        .dom_exec  (dom_executing),
        .next_gid  (next_gid),
        .cur_ld    (trk_clr.ld),
        .cur_st    (trk_clr.st),
        .cur_lb    (trk_clr.lb),
        .cur_sb    (trk_clr.sb),
        .dom       (dom_query_gid),
        .need_alloc(need_alloc),
        .gid       (gid),
        .ev        (ev),
        .ep        (ep),
        .eh        (eh),
        .nx_ld     (nx_ld),
        .nx_st     (nx_st),
        .nx_lb     (nx_lb),
        .nx_sb     (nx_sb)
    );

    memgrp_gid_alloc #(.GID_W(GID_W)) u_alloc (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc    (fire && need_alloc),
        .idle     (idle),
        .next_gid (next_gid),
        .can_alloc(can_alloc)
    );

    assign q_take[Q_LOAD]  = fire && in_may_load;
    assign q_take[Q_STORE] = fire && in_may_store;
    assign q_give[Q_LOAD]  = ret_load;
    assign q_give[Q_STORE] = ret_store;

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
        localparam int QD = (q == Q_LOAD) ? LQ_DEPTH : SQ_DEPTH;
        memgrp_qcount #(.DEPTH(QD)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .take (q_take[q]),
            .give (q_give[q]),
            .full (q_full[q])
        );
    end

    assign q_blocked = (in_may_load && q_full[Q_LOAD]) ||
                       (in_may_store && q_full[Q_STORE]);
    assign in_ready  = !q_blocked && (!need_alloc || can_alloc);
    assign fire      = in_valid && in_ready;

    always_comb begin
        if (in_may_load && q_full[Q_LOAD])        avail_status = AVL_LQ_FULL;
        else if (in_may_store && q_full[Q_STORE]) avail_status = AVL_SQ_FULL;
        else                                      avail_status = AVL_OK;
    end

    assign out_gid    = gid;
    assign edge_valid = ev;
    assign edge_pred  = ep;
    assign edge_hard  = eh;
    for (genvar e = 0; e < NUM_EDGES; e++) begin : g_succ
        assign edge_succ[e] = ev[e] ? gid : '0;
    end

    always_comb begin
        trk_d = trk_clr;
        if (fire) begin
            trk_d.ld = nx_ld;
            trk_d.st = nx_st;
            trk_d.lb = nx_lb;
            trk_d.sb = nx_sb;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end
endmodule

// File: rtl/memgrp_dispatch_chk.sv
module memgrp_dispatch_chk #(
    parameter int GID_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_may_load,
    input logic                  in_may_store,
    input logic                  in_barrier,
    input logic                  in_ready,
    input logic [1:0]            avail_status,
    input logic [GID_W-1:0]      out_gid,
    input logic [2:0]            edge_valid,
    input logic [2:0][GID_W-1:0] edge_pred,
    input logic [2:0][GID_W-1:0] edge_succ,
    input logic [2:0]            edge_hard,
    input logic [GID_W-1:0]      dom_query_gid,
    input logic                  done_valid,
    input logic [GID_W-1:0]      done_gid
);
    logic fire;
    assign fire = in_valid && in_ready;

    // R1
    a_r1_gid_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (in_may_load || in_may_store) |-> out_gid != '0);

    // R3: valid edges connect an existing older group to the reported one
    for (genvar e = 0; e < 3; e++) begin : g_edge
        a_r3_edge_ends: assert property (@(posedge clk) disable iff (!rst_n)
            edge_valid[e] |-> (edge_pred[e] != '0) && (edge_succ[e] == out_gid));
        a_r3_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
            !edge_valid[e] |-> (edge_pred[e] == '0) && !edge_hard[e]);
    end

    // R2: a store never lands in an existing load group
    a_r2_store_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        fire && in_may_store && dom_query_gid != '0 |-> out_gid != dom_query_gid);

    // R5: a joining load carries no edges
    a_r5_join_no_edges: assert property (@(posedge clk) disable iff (!rst_n)
        fire && in_may_load && !in_may_store && out_gid == dom_query_gid
        |-> edge_valid == 3'b000);

    // R6: a barrier load is ordered after the dominator
    a_r6_barrier_dom: assert property (@(posedge clk) disable iff (!rst_n)
        fire && in_may_load && !in_may_store && in_barrier && dom_query_gid != '0
        |-> edge_valid[1] && edge_pred[1] == dom_query_gid && edge_hard[1]);

    // R7: a full queue blocks acceptance
    a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        avail_status != 2'd0 |-> !in_ready);

    // R8
    a_r8_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        avail_status != 2'd3);

    // R9: a finished group no longer dominates when nothing is dispatched
    a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_gid != '0 && !fire |=> dom_query_gid != $past(done_gid));
endmodule

bind memgrp_dispatch memgrp_dispatch_chk #(.GID_W(GID_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_may_load  (in_may_load),
    .in_may_store (in_may_store),
    .in_barrier   (in_barrier),
    .in_ready     (in_ready),
    .avail_status (avail_status),
    .out_gid      (out_gid),
    .edge_valid   (edge_valid),
    .edge_pred    (edge_pred),
    .edge_succ    (edge_succ),
    .edge_hard    (edge_hard),
    .dom_query_gid(dom_query_gid),
    .done_valid   (done_valid),
    .done_gid     (done_gid)
);

// File: tb/memgrp_dispatch_test.sv
module memgrp_dispatch_test;
    localparam int GW = 4;

    logic clk = 1'b0;
    logic rst_n, no_alias, in_valid, in_may_load, in_may_store, in_barrier;
    logic in_ready;
    logic [1:0] avail_status;
    logic [GW-1:0] out_gid, dom_query_gid, done_gid;
    logic [2:0] edge_valid, edge_hard;
    logic [2:0][GW-1:0] edge_pred, edge_succ;
    logic dom_executing, done_valid, ret_load, ret_store;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    memgrp_dispatch #(.GID_W(GW), .LQ_DEPTH(16), .SQ_DEPTH(8)) uut (
        .clk(clk), .rst_n(rst_n), .no_alias(no_alias), .in_valid(in_valid),
        .in_may_load(in_may_load), .in_may_store(in_may_store),
        .in_barrier(in_barrier), .in_ready(in_ready),
        .avail_status(avail_status), .out_gid(out_gid),
        .edge_valid(edge_valid), .edge_pred(edge_pred),
        .edge_succ(edge_succ), .edge_hard(edge_hard),
        .dom_query_gid(dom_query_gid), .dom_executing(dom_executing),
        .done_valid(done_valid), .done_gid(done_gid),
        .ret_load(ret_load), .ret_store(ret_store)
    );

    typedef struct packed {
        logic ld; logic st; logic bar;
        logic [3:0] gid;
        logic [2:0] ev;
        logic [3:0] p0; logic [3:0] p1; logic [3:0] p2;
        logic [2:0] eh;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b0,1'b0, 4'd1,  3'b000, 4'd0, 4'd0, 4'd0, 3'b000},
        '{1'b1,1'b0,1'b0, 4'd1,  3'b000, 4'd0, 4'd0, 4'd0, 3'b000},
        '{1'b0,1'b1,1'b0, 4'd2,  3'b001, 4'd1, 4'd0, 4'd0, 3'b001},
        '{1'b1,1'b0,1'b0, 4'd3,  3'b001, 4'd2, 4'd0, 4'd0, 3'b001},
        '{1'b1,1'b0,1'b1, 4'd4,  3'b011, 4'd2, 4'd3, 4'd0, 3'b011},
        '{1'b1,1'b0,1'b0, 4'd5,  3'b011, 4'd2, 4'd4, 4'd0, 3'b011},
        '{1'b0,1'b1,1'b1, 4'd6,  3'b101, 4'd5, 4'd0, 4'd2, 3'b101},
        '{1'b0,1'b1,1'b0, 4'd7,  3'b011, 4'd5, 4'd6, 4'd0, 3'b011},
        '{1'b1,1'b1,1'b0, 4'd8,  3'b111, 4'd5, 4'd6, 4'd7, 3'b111},
        '{1'b1,1'b0,1'b0, 4'd9,  3'b011, 4'd8, 4'd4, 4'd0, 3'b011},
        '{1'b1,1'b0,1'b0, 4'd9,  3'b000, 4'd0, 4'd0, 4'd0, 3'b000},
        '{1'b1,1'b1,1'b1, 4'd10, 3'b111, 4'd9, 4'd6, 4'd8, 3'b111},
        '{1'b1,1'b0,1'b0, 4'd11, 3'b011, 4'd10,4'd10,4'd0, 3'b011}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_op(input logic v, input logic ld, input logic st, input logic bar);
        in_valid = v; in_may_load = ld; in_may_store = st; in_barrier = bar;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        set_op(0, 0, 0, 0);
        no_alias = 0; dom_executing = 0; done_valid = 0; done_gid = '0;
        ret_load = 0; ret_store = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic accept(input logic ld, input logic st, input logic bar);
        set_op(1, ld, st, bar);
        #1;
    endtask

    task automatic check_edges(input string req, input logic [2:0] ev,
                               input logic [3:0] p0, input logic [3:0] p1,
                               input logic [3:0] p2, input logic [2:0] eh);
        chk(req, 32'(edge_valid), 32'(ev));
        chk(req, 32'(edge_pred), 32'({p2, p1, p0}));
        chk(req, 32'(edge_hard), 32'(eh));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Reset state: R1, R8, R11
        set_op(0, 1, 0, 0);
        #1;
        chk("R11 reset dominator", 32'(dom_query_gid), 0);
        chk("R8 reset status", 32'(avail_status), 0);
        chk("R7 reset ready", 32'(in_ready), 1);
        chk("R1 first id", 32'(out_gid), 1);
        @(negedge clk);

        // Vector table: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            accept(TBL[i].ld, TBL[i].st, TBL[i].bar);
            chk($sformatf("R5/R2 table row %0d gid", i), 32'(out_gid), 32'(TBL[i].gid));
            check_edges($sformatf("R3/R6 table row %0d edges", i),
                        TBL[i].ev, TBL[i].p0, TBL[i].p1, TBL[i].p2, TBL[i].eh);
            chk($sformatf("R3 table row %0d succ", i), 32'(edge_succ[0]),
                32'(TBL[i].ev[0] ? TBL[i].gid : 4'd0));
            chk($sformatf("R4 table row %0d ready", i), 32'(in_ready), 1);
            step();
        end
        set_op(0, 0, 0, 0);

        // No-alias mode: R2 R3 R6
        do_reset();
        no_alias = 1;
        accept(1, 0, 0);
        chk("R1 no-alias load gid", 32'(out_gid), 1);
        step();
        accept(0, 1, 0);
        chk("R2 no-alias store gid", 32'(out_gid), 2);
        check_edges("R2 no-alias store soft edge", 3'b001, 4'd1, 4'd0, 4'd0, 3'b000);
        step();
        accept(1, 0, 0);
        chk("R6 no-alias load gid", 32'(out_gid), 3);
        check_edges("R6 no-alias load no store edge", 3'b000, 4'd0, 4'd0, 4'd0, 3'b000);
        step();
        accept(0, 1, 0);
        check_edges("R3 no-alias store pair", 3'b101, 4'd3, 4'd0, 4'd2, 3'b000);
        step();
        set_op(0, 0, 0, 0);

        // Executing dominator and completion: R5 R9 R11
        do_reset();
        accept(1, 0, 0);
        step();
        dom_executing = 1;
        accept(1, 0, 0);
        chk("R11 query shows load group", 32'(dom_query_gid), 1);
        chk("R5 executing dominator opens group", 32'(out_gid), 2);
        chk("R5 executing dominator edges", 32'(edge_valid), 0);
        step();
        dom_executing = 0;
        set_op(0, 0, 0, 0);
        done_valid = 1; done_gid = 4'd2;
        #1;
        chk("R9 same-cycle clear", 32'(dom_query_gid), 0);
        step();
        done_valid = 0;
        accept(1, 0, 0);
        chk("R9 load after clear opens group", 32'(out_gid), 3);
        step();
        accept(0, 1, 0);
        chk("R2 store gid", 32'(out_gid), 4);
        step();
        set_op(0, 0, 0, 0);
        done_valid = 1; done_gid = 4'd4;
        step();
        done_valid = 0;
        accept(0, 1, 0);
        chk("R9 cleared store tracker gid", 32'(out_gid), 5);
        check_edges("R9 cleared store tracker edges", 3'b001, 4'd3, 4'd0, 4'd0, 3'b001);
        step();
        set_op(0, 0, 0, 0);

        // Queue occupancy: R7 R8
        do_reset();
        for (int i = 0; i < 16; i++) begin
            accept(1, 0, 0);
            step();
        end
        for (int i = 0; i < 8; i++) begin
            accept(0, 1, 0);
            step();
        end
        set_op(0, 1, 1, 0);
        #1;
        chk("R8 both full reports load first", 32'(avail_status), 1);
        chk("R7 both full blocks", 32'(in_ready), 0);
        set_op(0, 0, 1, 0);
        #1;
        chk("R8 store queue full", 32'(avail_status), 2);
        chk("R7 store queue full blocks", 32'(in_ready), 0);
        ret_store = 1;
        step();
        ret_store = 0;
        #1;
        chk("R7 store slot freed", 32'(in_ready), 1);
        chk("R8 store available", 32'(avail_status), 0);
        set_op(0, 1, 0, 0);
        #1;
        chk("R7 load queue still full", 32'(in_ready), 0);
        ret_load = 1;
        step();
        ret_load = 0;
        #1;
        chk("R7 load slot freed", 32'(in_ready), 1);
        @(negedge clk);

        // ID exhaustion: R10
        do_reset();
        dom_executing = 1;
        for (int i = 0; i < 15; i++) begin
            accept(1, 0, 0);
            chk("R1 increasing ids", 32'(out_gid), 32'(i + 1));
            step();
        end
        set_op(0, 1, 0, 0);
        #1;
        chk("R10 stall after last id", 32'(in_ready), 0);
        dom_executing = 0;
        #1;
        chk("R10 join not stalled", 32'(in_ready), 1);
        dom_executing = 1;
        done_valid = 1; done_gid = 4'd15;
        #1;
        chk("R10 idle releases stall", 32'(in_ready), 1);
        step();
        done_valid = 0;
        accept(1, 0, 0);
        chk("R10 restart at one", 32'(out_gid), 1);
        step();
        set_op(0, 0, 0, 0);
        dom_executing = 0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule